// File: doc/BRIEF.md
# Iterative Signed Divider with Remainder Register

This unit performs signed integer division over many cycles and owns a dedicated remainder register, MQ. It has two operations. The long divide builds a 64-bit two's-complement dividend, with operand A as the upper word and the current MQ contents as the lower word, and divides it by operand B. The short divide divides the 32-bit signed operand A by B. In both cases the quotient is presented on the result port and the remainder is written back into MQ. Division truncates toward zero, so a non-zero remainder has the sign of the dividend.

The core is a restoring divider that works on magnitudes and produces one quotient bit per cycle. Signs are applied afterwards. A start request in an idle cycle latches every operand and control input. Busy then stays high until a single-cycle done pulse. Together with that pulse the unit reports the overflow flag, the sticky summary flag and a four-bit condition field, each with a write strobe that follows the overflow-enable and record controls given at start. Software can load and read MQ through a side port while the unit is idle.

Top module: `div_mq`

## Requirements
- R1: After reset, busy_o, done_o, quot_o, mq_o, cr_o, ov_o and so_o are all zero.
- R2: A start_i in a cycle where busy_o is low starts a divide. busy_o is high from the next cycle until the cycle before done_o. done_o is high for exactly one cycle, 65 clock edges after the start edge for a long divide and 33 for a short one. A start_i while busy_o is high is ignored.
- R3: With op_long_i=1, the dividend is the signed 64-bit value {A, MQ}, the divisor is signed B, quot_o gets the truncated quotient and MQ gets the remainder.
- R4: With op_long_i=0, quot_o gets the truncated quotient of signed 32-bit A divided by signed B, and MQ gets the remainder.
- R5: A non-zero remainder has the sign of the dividend. An exact division leaves MQ at zero.
- R6: If B is zero, or if the true quotient lies outside the range -2^31 to 2^31-1, the divide overflows. quot_o then becomes 0x8000_0000 and MQ becomes 0.
- R7: At done, ov_we_o pulses if oe_i was high at start. ov_o is high when the divide overflowed and oe_i was high at start. so_o equals so_i as sampled at start, ORed with ov_o.
- R8: At done, cr_we_o pulses if rc_i was high at start. cr_o uses bit 3 for quotient < 0, bit 2 for quotient > 0, bit 1 for quotient == 0 (all read as signed) and bit 0 for so_o.
- R9: Operands and controls (a_i, b_i, op_long_i, oe_i, rc_i, so_i) are latched at start. Changing them while busy has no effect on the result.
- R10: While busy_o and start_i are both low, mq_we_i loads mq_wdata_i into MQ at the next edge. mq_o always shows MQ. A write attempted while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken when idle |
| op_long_i | input | 1 | 1: 64/32 divide using {A, MQ}; 0: 32/32 divide |
| oe_i | input | 1 | Overflow reporting enable |
| rc_i | input | 1 | Condition field record enable |
| so_i | input | 1 | Incoming summary overflow state |
| a_i | input | 32 | Operand A (dividend, or upper dividend word) |
| b_i | input | 32 | Operand B (divisor) |
| mq_we_i | input | 1 | MQ side-port write enable |
| mq_wdata_i | input | 32 | MQ side-port write data |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 32 | Quotient of the last divide |
| mq_o | output | 32 | MQ register contents |
| ov_o | output | 1 | Overflow flag of the last divide |
| so_o | output | 1 | Summary overflow after the last divide |
| ov_we_o | output | 1 | Write strobe for ov_o and so_o |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |
| cr_we_o | output | 1 | Write strobe for cr_o |

## Verification
The assertions assume that the reset is released cleanly before the first start. They also assume that done, the strobes and MQ change only as a result of the unit's own sequencing, so that MQ is stable whenever busy has been high for two consecutive cycles. The stimulus respects this. It drives start only on idle cycles, except for the deliberate mid-run attempts, which must be ignored. It drops start and the MQ write enable before the done cycle, so that no second divide begins at once. During one run it scrambles every operand and control input and attempts an MQ write, and it compares the latched result with a reference computed in 64-bit integer arithmetic.

// File: rtl/div_mq_pkg.sv
package div_mq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_mq_prep.sv
// Sign extraction and magnitude forming for dividend and divisor.
module div_mq_prep #(
  parameter int XLEN = 32
) (
  input  logic                op_long_i,
  input  logic [XLEN-1:0]     a_i,
  input  logic [XLEN-1:0]     lo_i,
  input  logic [XLEN-1:0]     b_i,
  output logic [2*XLEN-1:0]   dvd_mag_o,
  output logic [XLEN-1:0]     dvs_mag_o,
  output logic                dvd_neg_o,
  output logic                dvs_neg_o,
  output logic                dvs_zero_o
);
  logic [2*XLEN-1:0] dvd_raw;

  always_comb begin
    dvd_raw    = op_long_i ? {a_i, lo_i} : {{XLEN{a_i[XLEN-1]}}, a_i};
    dvd_neg_o  = dvd_raw[2*XLEN-1];
    dvd_mag_o  = dvd_neg_o ? (~dvd_raw + 1'b1) : dvd_raw;
    dvs_neg_o  = b_i[XLEN-1];
    dvs_mag_o  = dvs_neg_o ? (~b_i + 1'b1) : b_i;
    dvs_zero_o = (b_i == '0);
  end
endmodule

// File: rtl/div_mq_core.sv
// Restoring unsigned divider, one quotient bit per step.
module div_mq_core #(
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              op_long_i,
  input  logic              step_i,
  input  logic [2*XLEN-1:0] dvd_i,
  input  logic [XLEN-1:0]   dvs_i,
  output logic [2*XLEN-1:0] quo_o,
  output logic [XLEN-1:0]   rem_o
);
  localparam int DLEN = 2 * XLEN;

  logic [XLEN-1:0] rem_q, dvs_q;
  logic [DLEN-1:0] dvd_q;
  logic [XLEN:0]   shifted, diff;
  logic            fits;

  always_comb begin
    shifted = {rem_q, dvd_q[DLEN-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = ~diff[XLEN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      dvs_q <= '0;
      dvd_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      dvs_q <= dvs_i;
      // short form: pre-shift so only XLEN steps are needed
      dvd_q <= op_long_i ? dvd_i : {dvd_i[XLEN-1:0], {XLEN{1'b0}}};
    end else if (step_i) begin
      rem_q <= fits ? diff[XLEN-1:0] : shifted[XLEN-1:0];
      dvd_q <= {dvd_q[DLEN-2:0], fits};
    end
  end

  assign quo_o = dvd_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/div_mq_post.sv
// Sign restore, range check and overflow substitution.
module div_mq_post #(
  parameter int XLEN = 32
) (
  input  logic [2*XLEN-1:0] qmag_i,
  input  logic [XLEN-1:0]   rmag_i,
  input  logic              dvd_neg_i,
  input  logic              q_neg_i,
  input  logic              dvs_zero_i,
  output logic [XLEN-1:0]   quot_o,
  output logic [XLEN-1:0]   rem_o,
  output logic              ovf_o
);
  localparam int DLEN = 2 * XLEN;
  localparam logic [DLEN-1:0] NEG_LIM = {{(DLEN-1){1'b0}}, 1'b1} << (XLEN - 1);
  localparam logic [DLEN-1:0] POS_LIM = NEG_LIM - 1'b1;
  localparam logic [XLEN-1:0] MIN_VAL = {1'b1, {(XLEN-1){1'b0}}};

  logic range_bad;

  always_comb begin
    range_bad = q_neg_i ? (qmag_i > NEG_LIM) : (qmag_i > POS_LIM);
    ovf_o     = dvs_zero_i | range_bad;
    if (ovf_o) begin
      quot_o = MIN_VAL;
      rem_o  = '0;
    end else begin
      quot_o = q_neg_i ? (~qmag_i[XLEN-1:0] + 1'b1) : qmag_i[XLEN-1:0];
      rem_o  = dvd_neg_i ? (~rmag_i + 1'b1) : rmag_i;
    end
  end
endmodule

// File: rtl/div_mq.sv
module div_mq
  import div_mq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            op_long_i,
  input  logic            oe_i,
  input  logic            rc_i,
  input  logic            so_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            mq_we_i,
  input  logic [XLEN-1:0] mq_wdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] quot_o,
  output logic [XLEN-1:0] mq_o,
  output logic            ov_o,
  output logic            so_o,
  output logic            ov_we_o,
  output logic [3:0]      cr_o,
  output logic            cr_we_o
);
  localparam int DLEN = 2 * XLEN;
  localparam int CW   = $clog2(DLEN);

  div_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic            dvd_neg_q, q_neg_q, dvs_zero_q, oe_q, rc_q, so_in_q;
  logic [XLEN-1:0] quot_q, mq_q;
  logic            ov_q, so_q, done_q, ov_we_q, cr_we_q;
  logic [3:0]      cr_q;

  logic [DLEN-1:0] dvd_mag, qmag;
  logic [XLEN-1:0] dvs_mag, rmag, quot_fix, rem_fix;
  logic            dvd_neg, dvs_neg, dvs_zero, ovf, accept, step;
  logic            so_new, lt, eq;

  assign accept = start_i && (state_q == ST_IDLE);
  assign step   = (state_q == ST_RUN);

  div_mq_prep #(.XLEN(XLEN)) u_prep (
    .op_long_i (op_long_i),
    .a_i       (a_i),
    .lo_i      (mq_q),
    .b_i       (b_i),
    .dvd_mag_o (dvd_mag),
    .dvs_mag_o (dvs_mag),
    .dvd_neg_o (dvd_neg),
    .dvs_neg_o (dvs_neg),
    .dvs_zero_o(dvs_zero)
  );

  div_mq_core #(.XLEN(XLEN)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .op_long_i(op_long_i),
    .step_i   (step),
    .dvd_i    (dvd_mag),
    .dvs_i    (dvs_mag),
    .quo_o    (qmag),
    .rem_o    (rmag)
  );

  div_mq_post #(.XLEN(XLEN)) u_post (
    .qmag_i    (qmag),
    .rmag_i    (rmag),
    .dvd_neg_i (dvd_neg_q),
    .q_neg_i   (q_neg_q),
    .dvs_zero_i(dvs_zero_q),
    .quot_o    (quot_fix),
    .rem_o     (rem_fix),
    .ovf_o     (ovf)
  );

  always_comb begin
    so_new = so_in_q | (oe_q & ovf);
    lt     = quot_fix[XLEN-1];
    eq     = (quot_fix == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      dvd_neg_q  <= 1'b0;
      q_neg_q    <= 1'b0;
      dvs_zero_q <= 1'b0;
      oe_q       <= 1'b0;
      rc_q       <= 1'b0;
      so_in_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q    <= ST_RUN;
          cnt_q      <= op_long_i ? CW'(DLEN - 1) : CW'(XLEN - 1);
          dvd_neg_q  <= dvd_neg;
          q_neg_q    <= dvd_neg ^ dvs_neg;
          dvs_zero_q <= dvs_zero;
          oe_q       <= oe_i;
          rc_q       <= rc_i;
          so_in_q    <= so_i;
        end
        ST_RUN: begin
          if (cnt_q == '0) state_q <= ST_FIN;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_q  <= '0;
      mq_q    <= '0;
      ov_q    <= 1'b0;
      so_q    <= 1'b0;
      cr_q    <= '0;
      done_q  <= 1'b0;
      ov_we_q <= 1'b0;
      cr_we_q <= 1'b0;
    end else begin
      done_q  <= (state_q == ST_FIN);
      ov_we_q <= (state_q == ST_FIN) && oe_q;
      cr_we_q <= (state_q == ST_FIN) && rc_q;
      if (state_q == ST_FIN) begin
        quot_q <= quot_fix;
        mq_q   <= rem_fix;
        ov_q   <= oe_q & ovf;
        so_q   <= so_new;
        cr_q   <= {lt, ~lt & ~eq, eq, so_new};
      end else if (mq_we_i && (state_q == ST_IDLE) && !start_i) begin
        mq_q <= mq_wdata_i;
      end
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign quot_o  = quot_q;
  assign mq_o    = mq_q;
  assign ov_o    = ov_q;
  assign so_o    = so_q;
  assign ov_we_o = ov_we_q;
  assign cr_o    = cr_q;
  assign cr_we_o = cr_we_q;
endmodule

// File: rtl/div_mq_chk.sv
module div_mq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [XLEN-1:0] quot_o,
  input logic [XLEN-1:0] mq_o,
  input logic            ov_o,
  input logic            so_o,
  input logic            ov_we_o,
  input logic [3:0]      cr_o,
  input logic            cr_we_o
);
  localparam logic [XLEN-1:0] MIN_VAL = {1'b1, {(XLEN-1){1'b0}}};

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_done_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_busy_from_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  p_mq_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mq_o));
  p_ovf_value_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ov_o) |-> (quot_o == MIN_VAL && mq_o == '0));
  p_so_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ov_o) |-> (so_o && cr_o[0]));
  p_ov_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ov_we_o) |-> !ov_o);
  p_strobe_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_we_o || cr_we_o) |-> done_o);
  p_cr_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones(cr_o[3:1]) == 1));
endmodule

bind div_mq div_mq_chk #(.XLEN(XLEN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .quot_o (quot_o),
  .mq_o   (mq_o),
  .ov_o   (ov_o),
  .so_o   (so_o),
  .ov_we_o(ov_we_o),
  .cr_o   (cr_o),
  .cr_we_o(cr_we_o)
);

// File: tb/div_mq_bench.sv
module div_mq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, op_long_i = 1'b0, oe_i = 1'b0, rc_i = 1'b0, so_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, mq_wdata_i = '0;
  logic        mq_we_i = 1'b0;
  logic        busy_o, done_o, ov_o, so_o, ov_we_o, cr_we_o;
  logic [31:0] quot_o, mq_o;
  logic [3:0]  cr_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] mdl_mq = '0;

  always #10 clk_i = ~clk_i;

  div_mq u_div_mq (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic mq_write(input logic [31:0] d);
    @(negedge clk_i);
    mq_we_i = 1'b1; mq_wdata_i = d;
    @(negedge clk_i);
    mq_we_i = 1'b0;
    mdl_mq = d;
    chk("R10 mq write", mq_o, d);
  endtask

  // behavioural reference: 64-bit integer arithmetic
  task automatic run_div(input bit lng, input logic [31:0] a, input logic [31:0] b,
                         input bit oe, input bit rc, input bit so, input bit disturb);
    longint dv, ds, q, r;
    bit ovf, lt, gt, eq, so_x;
    int n;
    dv = lng ? longint'($signed({a, mdl_mq})) : longint'($signed(a));
    ds = longint'($signed(b));
    ovf = 0; q = 0; r = 0;
    if (ds == 0) ovf = 1;
    else if (dv == 64'sh8000_0000_0000_0000 && ds == -1) ovf = 1;
    else begin
      q = dv / ds;
      r = dv % ds;
      if (q > 64'sd2147483647 || q < -64'sd2147483648) ovf = 1;
    end
    if (ovf) begin q = -64'sd2147483648; r = 0; end
    lt = q < 0; gt = q > 0; eq = q == 0;
    so_x = so | (oe & ovf);
    n = lng ? 64 : 32;

    @(negedge clk_i);
    start_i = 1'b1; op_long_i = lng; a_i = a; b_i = b; oe_i = oe; rc_i = rc; so_i = so;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (disturb && k == 3) begin
        // R9 / R10 / R2: all of these must be ignored while busy
        start_i = 1'b1; op_long_i = ~lng; a_i = ~a; b_i = 32'h5; oe_i = ~oe;
        rc_i = ~rc; so_i = ~so; mq_we_i = 1'b1; mq_wdata_i = 32'hdead_beef;
      end
      if (disturb && k == 4) begin
        start_i = 1'b0; mq_we_i = 1'b0;
      end
      chk("R2 busy", {63'd0, busy_o}, 64'd1);
      chk("R2 done low", {63'd0, done_o}, 64'd0);
      chk("R7 strobe low", {62'd0, ov_we_o, cr_we_o}, 64'd0);
    end
    @(negedge clk_i);
    chk("R2 done", {62'd0, done_o, busy_o}, 64'd2);
    chk(lng ? "R3 quotient" : "R4 quotient", {32'd0, quot_o}, {32'd0, q[31:0]});
    chk(ovf ? "R6 mq" : "R5 remainder", {32'd0, mq_o}, {32'd0, r[31:0]});
    chk("R7 flags", {61'd0, ov_we_o, ov_o, so_o}, {61'd0, oe, oe & ovf, so_x});
    chk("R8 cr", {59'd0, cr_we_o, cr_o}, {59'd0, rc, lt, gt, eq, so_x});
    mdl_mq = r[31:0];
    @(negedge clk_i);
    chk("R2 done single", {63'd0, done_o}, 64'd0);
    chk("R10 mq held", {32'd0, mq_o}, {32'd0, mdl_mq});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #5;
    chk("R1 reset", {busy_o, done_o, ov_o, so_o, cr_o, quot_o}, 64'd0);
    chk("R1 reset mq", {32'd0, mq_o}, 64'd0);
    #30 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", {62'd0, busy_o, done_o}, 64'd0);

    // R4 short forms
    run_div(0, 32'd100, 32'd7, 1, 1, 0, 0);
    run_div(0, -32'sd100, 32'd7, 0, 1, 0, 0);            // R5 negative remainder
    run_div(0, 32'd100, -32'sd7, 1, 0, 0, 0);            // R5 positive remainder
    run_div(0, 32'd0, 32'd5, 1, 1, 0, 0);                // EQ
    run_div(0, 32'd7, 32'd0, 1, 1, 0, 0);                // R6 divide by zero
    run_div(0, 32'h8000_0000, 32'hffff_ffff, 1, 1, 0, 0);// R6 range
    run_div(0, 32'd9, 32'd0, 0, 1, 1, 0);                // R7 so passes, ov gated

    // R3 long forms using MQ as low word
    mq_write(32'd100);
    run_div(1, 32'd0, 32'd7, 1, 1, 0, 0);
    mq_write(32'hffff_ff9c);
    run_div(1, 32'hffff_ffff, 32'd7, 1, 1, 0, 0);
    mq_write(32'd0);
    run_div(1, 32'd1, 32'd3, 1, 1, 0, 0);
    mq_write(32'd0);
    run_div(1, 32'd1, 32'd1, 1, 1, 0, 0);                // R6 quotient 2^32
    mq_write(32'h8000_0000);
    run_div(1, 32'd0, 32'd1, 1, 1, 0, 0);                // R6 quotient +2^31
    mq_write(32'h8000_0000);
    run_div(1, 32'hffff_ffff, 32'd1, 1, 1, 0, 0);        // -2^31 fits
    mq_write(32'h1234_5678);
    run_div(1, 32'hfff0_0000, 32'h7fff_ffff, 1, 1, 0, 0);

    // R9 / R10: inputs scrambled and MQ written mid-run
    mq_write(32'd55);
    run_div(1, 32'd0, 32'd4, 1, 1, 0, 1);
    run_div(0, -32'sd1000, 32'd33, 1, 1, 0, 1);
    // R5 exact long division chained through MQ (remainder 0 feeds next)
    run_div(1, 32'd0, 32'd3, 1, 1, 0, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule